// File: doc/BRIEF.md
# Strength Lattice Join Unit

This block merges two switch-level node values into the single value that the node settles to when both drivers act on it at once. A value is either Nil or a logic state with a range of possible drive strengths. Nil means nothing drives the node. The logic state is high, low or unknown. Three real strengths are modelled: float (f) is the weakest, resistive (r) is next and active (a) is the strongest. Nil ranks below all three.

The unit is purely combinational. The joined code is a function of the two input codes only, so two units can be chained, or the output fed back as an input, to resolve a node with more than two drivers. Alongside the joined code, the unit gives a boolean reading of the result. That reading is the level for a resolved high or low, and a flag for anything that does not resolve.

Each non-Nil value is read as a closed range on the signed strength scale -3, -2, -1, +1, +2, +3. In this scale f=1, r=2 and a=3. A positive number is a pull to high and a negative number is a pull to low. Each end of the merged range is taken from the matching ends of the two inputs:
- The lower end is the stronger of the two lower ends. If the two have equal strength, the low-side one wins.
- The upper end is the stronger of the two upper ends. If the two have equal strength, the high-side one wins.

Each of these two choices is a maximum along a fixed chain, so the result is the least upper bound in a 22-member lattice with Nil at the bottom.

Top module: `slj_join_unit`

## Requirements
- R1: Codes are 5 bits wide and use the following assignments.
  - Code 0 is Nil.
  - Codes 1..6 are the high values 1ff, 1rf, 1rr, 1af, 1ar, 1aa. Value 1pq means driven high at a strength from q up to p.
  - Codes 7..12 are the low values 0ff, 0rf, 0rr, 0af, 0ar, 0aa, with the same p and q meaning.
  - Codes 13..21 are the unknown values Xpq, with code 13 + 3(p-1) + (q-1), where f=1, r=2, a=3. Xpq covers everything from low at strength q to high at strength p.
- R2: Codes 22..31 are treated exactly as Nil. Joining any value with Nil returns that value's code, and joining Nil with Nil returns 0.
- R3: Joining a valid code with itself returns the same code.
- R4: Swapping the two inputs never changes the joined code.
- R5: The join is associative: join(x, join(y, z)) equals join(join(x, y), z) for all valid x, y, z.
- R6: For two non-Nil inputs, the result range follows the endpoint rule given in the description: a stronger endpoint wins, and an equal-strength tie goes low for the lower end and high for the upper end. For example, 1af joined with 0rr gives Xar (code 20), and Xfr (14) joined with 1rr (3) gives Xrr (17).
- R7: Two opposing drivers of equal strength give an unknown value. 1rr (3) joined with 0rr (9) gives Xrr (17), and 1ff (1) joined with 0ff (7) gives Xff (13).
- R8: A driver that is stronger than every possible strength of the opposing driver dominates. 1aa (6) joined with 0rr (9) gives 1aa (6).
- R9: The order "x is below y when join(x, y) = y" has exactly 32 covering pairs over the 22 values. Xaa (21) is the top, so joining it with any value gives 21.
- R10: j_level and j_unknown depend on the class of the joined value:
  - A high result (codes 1..6) gives j_level=1 and j_unknown=0.
  - A low result (codes 7..12) gives j_level=0 and j_unknown=0.
  - An unknown result or Nil gives j_unknown=1 and j_level=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_code | input | 5 | First driver value code |
| b_code | input | 5 | Second driver value code |
| j_code | output | 5 | Joined value code |
| j_level | output | 1 | Boolean level of the joined value |
| j_unknown | output | 1 | Joined value does not resolve to a level |

## Verification
Some properties are checked on every evaluation by assertions:
- a value joined with itself comes back unchanged;
- a Nil or out-of-range input leaves the other operand unchanged;
- the top value absorbs everything;
- every merged range is well-formed, with each end taken from one of the inputs;
- the level and unknown outputs are never both set.

Other properties can only be shown by the bench's scenarios, because each needs several evaluations compared against one another:
- the exact merged codes for every pair;
- commutativity;
- associativity over all triples;
- the count of covering pairs in the derived order.

// File: rtl/slj_pkg.sv
package slj_pkg;

  // number of real strengths (float, resistive, active); Nil sits below them
  localparam int NSTR       = 3;
  localparam int MAG_W      = $clog2(NSTR + 1);
  localparam int NTRI       = NSTR * (NSTR + 1) / 2;
  localparam int NUNK       = NSTR * NSTR;
  localparam int NVAL       = 1 + 2 * NTRI + NUNK;
  localparam int CODE_W     = $clog2(NVAL);
  localparam int TRUE_BASE  = 1;
  localparam int FALSE_BASE = TRUE_BASE + NTRI;
  localparam int UNK_BASE   = FALSE_BASE + NTRI;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [MAG_W-1:0]  mag_t;

  // one end of a strength range: sign (low side) and magnitude 1..NSTR
  typedef struct packed {
    logic neg;
    mag_t mag;
  } edge_t;

  typedef struct packed {
    logic  nil;
    edge_t lo;
    edge_t hi;
  } span_t;

  typedef enum logic [1:0] {
    CLS_NIL,
    CLS_HIGH,
    CLS_LOW,
    CLS_UNK
  } cls_t;

  // position of (strong p, weak q), q <= p, in the triangular listing
  function automatic int tri_index(int p, int q);
    return p * (p - 1) / 2 + q - 1;
  endfunction

  function automatic int edge_val(edge_t e);
    return e.neg ? -int'(e.mag) : int'(e.mag);
  endfunction

  // chain used for lower ends: equal strength ranks the low side higher
  function automatic int lo_rank(edge_t e);
    return 2 * (int'(e.mag) - 1) + (e.neg ? 1 : 0);
  endfunction

  // chain used for upper ends: equal strength ranks the high side higher
  function automatic int hi_rank(edge_t e);
    return 2 * (int'(e.mag) - 1) + (e.neg ? 0 : 1);
  endfunction

  function automatic span_t code_to_span(code_t c);
    span_t s;
    int    k;
    int    idx;
    s     = '0;
    s.nil = 1'b1;
    k     = int'(c);
    if (k >= TRUE_BASE && k < UNK_BASE) begin
      idx = (k < FALSE_BASE) ? (k - TRUE_BASE) : (k - FALSE_BASE);
      for (int p = 1; p <= NSTR; p++) begin
        for (int q = 1; q <= p; q++) begin
          if (tri_index(p, q) == idx) begin
            s.nil = 1'b0;
            if (k < FALSE_BASE) begin
              s.lo = '{neg: 1'b0, mag: mag_t'(q)};
              s.hi = '{neg: 1'b0, mag: mag_t'(p)};
            end else begin
              s.lo = '{neg: 1'b1, mag: mag_t'(p)};
              s.hi = '{neg: 1'b1, mag: mag_t'(q)};
            end
          end
        end
      end
    end else if (k >= UNK_BASE && k < NVAL) begin
      idx   = k - UNK_BASE;
      s.nil = 1'b0;
      s.hi  = '{neg: 1'b0, mag: mag_t'(idx / NSTR + 1)};
      s.lo  = '{neg: 1'b1, mag: mag_t'(idx % NSTR + 1)};
    end
    return s;
  endfunction

  function automatic code_t span_to_code(span_t s);
    int k;
    if (s.nil) begin
      k = 0;
    end else if (!s.lo.neg) begin
      k = TRUE_BASE + tri_index(int'(s.hi.mag), int'(s.lo.mag));
    end else if (s.hi.neg) begin
      k = FALSE_BASE + tri_index(int'(s.lo.mag), int'(s.hi.mag));
    end else begin
      k = UNK_BASE + (int'(s.hi.mag) - 1) * NSTR + (int'(s.lo.mag) - 1);
    end
    return code_t'(k);
  endfunction

endpackage

// File: rtl/slj_decode.sv
module slj_decode
  import slj_pkg::*;
(
  input  code_t code,
  output span_t span
);

  always_comb begin
    span = code_to_span(code);
  end

  // R1: every non-Nil range is well-formed and inside the strength scale
  always_comb begin
    if (!span.nil) begin
      a_r1_span_legal: assert (edge_val(span.lo) <= edge_val(span.hi)
                               && span.lo.mag != '0 && span.hi.mag != '0)
        else $error("decoded range malformed for code %0d", code);
    end
  end

endmodule

// File: rtl/slj_merge.sv
module slj_merge
  import slj_pkg::*;
(
  input  span_t a,
  input  span_t b,
  output span_t y
);

  always_comb begin
    if (a.nil) begin
      y = b;
    end else if (b.nil) begin
      y = a;
    end else begin
      y.nil = 1'b0;
      y.lo  = (lo_rank(a.lo) >= lo_rank(b.lo)) ? a.lo : b.lo;
      y.hi  = (hi_rank(a.hi) >= hi_rank(b.hi)) ? a.hi : b.hi;
    end
  end

  // R6: merged range is ordered and each end comes from an input end
  always_comb begin
    if (!a.nil && !b.nil) begin
      a_r6_range_ordered: assert (!y.nil && edge_val(y.lo) <= edge_val(y.hi))
        else $error("merged range out of order");
      a_r6_ends_from_inputs: assert ((y.lo == a.lo || y.lo == b.lo)
                                     && (y.hi == a.hi || y.hi == b.hi))
        else $error("merged range end not taken from an input");
    end
  end

endmodule

// File: rtl/slj_encode.sv
module slj_encode
  import slj_pkg::*;
(
  input  span_t span,
  output code_t code
);

  always_comb begin
    code = span_to_code(span);
  end

  // R1: only the 22 defined codes are ever produced
  always_comb begin
    a_r1_code_in_set: assert (int'(code) < NVAL)
      else $error("encoded code %0d outside value set", code);
  end

endmodule

// File: rtl/slj_abstract.sv
module slj_abstract
  import slj_pkg::*;
(
  input  span_t span,
  output logic  level,
  output logic  unknown
);

  cls_t cls;

  always_comb begin
    if (span.nil)          cls = CLS_NIL;
    else if (!span.lo.neg) cls = CLS_HIGH;
    else if (span.hi.neg)  cls = CLS_LOW;
    else                   cls = CLS_UNK;
  end

  always_comb begin
    level   = (cls == CLS_HIGH);
    unknown = (cls == CLS_NIL) || (cls == CLS_UNK);
  end

  // R10: a level is never reported together with the unknown flag
  always_comb begin
    a_r10_level_excl_unknown: assert (!(level && unknown))
      else $error("level and unknown both asserted");
  end

endmodule

// File: rtl/slj_join_unit.sv
module slj_join_unit
  import slj_pkg::*;
(
  input  logic [CODE_W-1:0] a_code,
  input  logic [CODE_W-1:0] b_code,
  output logic [CODE_W-1:0] j_code,
  output logic              j_level,
  output logic              j_unknown
);

  localparam int NIN = 2;

  code_t in_code [NIN];
  span_t in_span [NIN];
  span_t join_span;

  assign in_code[0] = a_code;
  assign in_code[1] = b_code;

  for (genvar i = 0; i < NIN; i++) begin : g_dec
    slj_decode u_dec (
      .code (in_code[i]),
      .span (in_span[i])
    );
  end

  slj_merge u_merge (
    .a (in_span[0]),
    .b (in_span[1]),
    .y (join_span)
  );

  slj_encode u_enc (
    .span (join_span),
    .code (j_code)
  );

  slj_abstract u_abs (
    .span    (join_span),
    .level   (j_level),
    .unknown (j_unknown)
  );

  // port-level lattice properties
  always_comb begin
    if (a_code == b_code && int'(a_code) < NVAL) begin
      a_r3_idempotent: assert (j_code == a_code)
        else $error("self join changed code %0d to %0d", a_code, j_code);
    end
    if (int'(b_code) == 0 || int'(b_code) >= NVAL) begin
      a_r2_nil_identity: assert (j_code == ((int'(a_code) < NVAL) ? a_code : code_t'(0)))
        else $error("Nil operand altered result");
    end
    if (int'(a_code) == NVAL - 1 || int'(b_code) == NVAL - 1) begin
      a_r9_top_absorbs: assert (int'(j_code) == NVAL - 1)
        else $error("top value did not absorb");
    end
  end

endmodule

// File: tb/sim_slj_join_unit.sv
`timescale 1ns/1ps
module sim_slj_join_unit;

  localparam int NV = 22;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] a_code;
  logic [4:0] b_code;
  logic [4:0] j_code;
  logic       j_level;
  logic       j_unknown;

  int n_tests = 0;
  int n_fail  = 0;
  int jt [NV][NV];

  always #2 clk = ~clk;

  slj_join_unit u0 (
    .a_code    (a_code),
    .b_code    (b_code),
    .j_code    (j_code),
    .j_level   (j_level),
    .j_unknown (j_unknown)
  );

  // ---------------- behavioural reference ----------------
  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic void ref_dec(input int c, output bit nil, output int lo, output int hi);
    int k;
    int n;
    nil = 1'b1; lo = 0; hi = 0;
    if (c >= 1 && c <= 12) begin
      k = (c <= 6) ? c - 1 : c - 7;
      n = 0;
      for (int p = 1; p <= 3; p++) begin
        for (int q = 1; q <= p; q++) begin
          if (n == k) begin
            nil = 1'b0;
            if (c <= 6) begin lo = q;  hi = p;  end
            else        begin lo = -p; hi = -q; end
          end
          n++;
        end
      end
    end else if (c >= 13 && c <= 21) begin
      nil = 1'b0;
      hi  = (c - 13) / 3 + 1;
      lo  = -((c - 13) % 3 + 1);
    end
  endfunction

  function automatic int ref_pos(int p, int q);
    int n;
    int r;
    n = 0; r = 0;
    for (int pp = 1; pp <= 3; pp++) begin
      for (int qq = 1; qq <= pp; qq++) begin
        if (pp == p && qq == q) r = n;
        n++;
      end
    end
    return r;
  endfunction

  function automatic int ref_enc(bit nil, int lo, int hi);
    if (nil)    return 0;
    if (lo > 0) return 1 + ref_pos(hi, lo);
    if (hi < 0) return 7 + ref_pos(-lo, -hi);
    return 13 + 3 * (hi - 1) + (-lo - 1);
  endfunction

  function automatic int pick_lo(int x, int y);
    if (iabs(x) > iabs(y)) return x;
    if (iabs(y) > iabs(x)) return y;
    return (x < y) ? x : y;
  endfunction

  function automatic int pick_hi(int x, int y);
    if (iabs(x) > iabs(y)) return x;
    if (iabs(y) > iabs(x)) return y;
    return (x > y) ? x : y;
  endfunction

  function automatic int ref_join(int a, int b);
    bit na, nb;
    int la, ha, lb, hb;
    ref_dec(a, na, la, ha);
    ref_dec(b, nb, lb, hb);
    if (na) return ref_enc(nb, lb, hb);
    if (nb) return ref_enc(na, la, ha);
    return ref_enc(1'b0, pick_lo(la, lb), pick_hi(ha, hb));
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // apply one pair per clock and compare against the reference
  task automatic drive(input int a, input int b, output int j);
    int e;
    @(negedge clk);
    a_code = 5'(a);
    b_code = 5'(b);
    @(posedge clk);
    #1;
    j = int'(j_code);
    e = ref_join(a, b);
    chk("R6", $sformatf("join(%0d,%0d)", a, b), j, e);
    chk("R10", $sformatf("level of %0d", e), int'(j_level), (e >= 1 && e <= 6) ? 1 : 0);
    chk("R10", $sformatf("unknown of %0d", e), int'(j_unknown), (e == 0 || e >= 13) ? 1 : 0);
  endtask

  initial begin
    #600000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int j;
    int l;
    int r;
    int ncov;
    bit between;
    rst    = 1'b1;
    a_code = '0;
    b_code = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R2", "reset-state code", int'(j_code), 0);
    chk("R10", "reset-state unknown", int'(j_unknown), 1);
    chk("R10", "reset-state level", int'(j_level), 0);
    rst = 1'b0;

    // directed cases
    drive(3, 9, j);   chk("R7", "1rr+0rr", j, 17);
    drive(1, 7, j);   chk("R7", "1ff+0ff", j, 13);
    drive(6, 9, j);   chk("R8", "1aa+0rr", j, 6);
    drive(4, 9, j);   chk("R6", "1af+0rr", j, 20);
    drive(14, 3, j);  chk("R6", "Xfr+1rr", j, 17);
    drive(25, 4, j);  chk("R2", "invalid+1af", j, 4);
    drive(31, 31, j); chk("R2", "invalid+invalid", j, 0);
    drive(12, 23, j); chk("R2", "0aa+invalid", j, 12);

    // every pair
    for (int a = 0; a < NV; a++) begin
      for (int b = 0; b < NV; b++) begin
        drive(a, b, j);
        jt[a][b] = j;
      end
    end
    for (int a = 0; a < NV; a++) begin
      chk("R3", $sformatf("self join %0d", a), jt[a][a], a);
      chk("R2", $sformatf("Nil right %0d", a), jt[a][0], a);
      chk("R2", $sformatf("Nil left %0d", a), jt[0][a], a);
      chk("R9", $sformatf("top absorbs %0d", a), jt[21][a], 21);
      for (int b = 0; b < NV; b++) begin
        chk("R4", $sformatf("swap %0d,%0d", a, b), jt[a][b], jt[b][a]);
      end
    end

    // associativity, both groupings evaluated by the unit
    for (int a = 0; a < NV; a++) begin
      for (int b = 0; b < NV; b++) begin
        for (int c = 0; c < NV; c++) begin
          drive(a, jt[b][c], l);
          drive(jt[a][b], c, r);
          chk("R5", $sformatf("assoc %0d,%0d,%0d", a, b, c), l, r);
        end
      end
    end

    // covering pairs of the order derived from the unit's joins
    ncov = 0;
    for (int x = 0; x < NV; x++) begin
      for (int y = 0; y < NV; y++) begin
        if (x != y && jt[x][y] == y) begin
          between = 1'b0;
          for (int z = 0; z < NV; z++) begin
            if (z != x && z != y && jt[x][z] == z && jt[z][y] == y) between = 1'b1;
          end
          if (!between) ncov++;
        end
      end
    end
    chk("R9", "covering pair count", ncov, 32);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule